// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is a single DMA channel that streams bytes from memory to one peripheral port. Software describes work through two buffer slots. Each slot holds a start address and a byte count. The channel drains one slot at a time and then turns to the other, so software can refill the slot just freed while the second one is being sent. A small register file gives access to the channel control word, the pending interrupt flags, the peripheral port number, the channel state and both slots.

Each byte moves through a fixed handshake. A peripheral request starts a one-byte memory read at the active slot's current address. The returned byte is then handed to the peripheral with a one-cycle acknowledge. After that the slot's address goes up by one and its count goes down by one. When a slot empties, the channel raises a next-buffer flag if the other slot is loaded, or a stall flag if it is not. A memory response marked as faulty raises an error flag, drops what is left of that slot and moves on.

Top module: `pdma_channel`

## Requirements
- R1: After reset every register reads zero, the channel state is idle (0), and `irq`, `memReq` and `perAck` are low.
- R2: Register 0x08 keeps the low 4 bits of a write as the peripheral port number, reads them back and drives them on `perPort`. Control register 0x00 keeps only bits 0, 1, 3, 4 and 6.
- R3: Status register 0x0C reports the channel state in bits [5:4]: 0 idle, 1 stall, 2 on, 3 next. With the enable bit (control bit 4) clear, the state is idle. With it set, the state is stall when no slot holds a nonzero count, on when exactly one does, and next when both do.
- R4: Slot 0 has its count at 0x20 and its address at 0x24; slot 1 has its count at 0x30 and its address at 0x34. A count write keeps the low 16 bits. Each byte is read from memory at the slot's address and presented on `perData` during a one-cycle `perAck`. After each byte the slot's address reads one higher and its count one lower.
- R5: After reset, slot 0 is served first, and the slots then alternate. When the active slot empties and the other slot is loaded, the channel turns to it and sets the next-buffer flag (register 0x04 bit 1).
- R6: When the active slot empties and the other slot is empty, the channel sets the stall flag (register 0x04 bit 0) and reports the stall state.
- R7: Any write to either count register clears the stall and next-buffer flags. A count of zero loads nothing.
- R8: A memory response with `memErr` set delivers no byte. It sets the error flag (register 0x04 bit 3), clears the rest of that slot and sets the next-buffer or stall flag as in R5/R6. Any write to 0x04 clears the error flag.
- R9: `irq` is high exactly when control bit 6 is set and at least one flag is set together with its enable: stall with bit 0, next-buffer with bit 1, error with bit 3.
- R10: Clearing the enable bit lets a byte already in flight finish. The channel then goes idle and both counts read zero. Count writes made while the channel is disabled are discarded.
- R11: `memReq` and `memAddr` stay unchanged until `memValid` answers the request.
- R12: `perAck` lasts exactly one cycle and follows a fault-free memory response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte offset |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational from regAddr) |
| memReq | output | 1 | Memory read request, held until answered |
| memAddr | output | 32 | Memory read byte address |
| memValid | input | 1 | Memory response valid |
| memRdata | input | 8 | Memory response byte |
| memErr | input | 1 | Memory response carries a fault |
| perReq | input | 1 | Peripheral wants a byte |
| perAck | output | 1 | Byte on perData is delivered this cycle |
| perData | output | 8 | Byte to the peripheral |
| perPort | output | 4 | Selected peripheral port number |
| irq | output | 1 | Channel interrupt |

## Verification
The assertions assume the memory side gives at most one `memValid` per request, and only while `memReq` is high. The bench's memory model answers exactly one cycle after it sees a request and then drops `memValid`, so it never violates the hold rule of R11. Register writes are made only at falling edges. The disable test removes the enable bit while a memory read is outstanding, which exercises the drain path of R10 without ever having two responses in flight.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_STALL = 2'd1,
    CH_ON    = 2'd2,
    CH_NEXT  = 2'd3
  } chState_e;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_READ = 2'd1,
    PH_PUSH = 2'd2
  } phase_e;

  // register offsets
  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_FLAGS  = 8'h04;
  localparam logic [7:0] OFF_PORT   = 8'h08;
  localparam logic [7:0] OFF_STATUS = 8'h0C;
  localparam logic [7:0] OFF_SLOT0  = 8'h20;
  localparam logic [7:0] SLOT_STEP  = 8'h10;
  localparam logic [7:0] OFF_BASE   = 8'h04;

  // control and flag bit positions
  localparam int BIT_STALL = 0;
  localparam int BIT_NFB   = 1;
  localparam int BIT_ERR   = 3;
  localparam int BIT_EN    = 4;
  localparam int BIT_IRQEN = 6;
  localparam int CTRL_W    = 7;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 7'b101_1011;

  localparam int STATE_LSB = 4;

  typedef struct packed {
    logic advance;   // one byte delivered from the selected slot
    logic abortSlot; // drop the rest of the selected slot
    logic flush;     // empty both slots
    logic loadData;  // capture the memory byte
    logic setNfb;
    logic setStall;
    logic setErr;
    logic slotSel;
  } ctlStrobe_t;

endpackage

// File: rtl/pdma_regs_dp.sv
module pdma_regs_dp
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int REG_AW = 8,
  parameter int REG_DW = 32,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWe,
  input  logic [REG_DW-1:0] regWdata,
  output logic [REG_DW-1:0] regRdata,
  input  ctlStrobe_t        strb,
  input  chState_e          chState,
  input  logic [DATA_W-1:0] memRdata,
  output logic [1:0]        slotLive,
  output logic              curCountIsOne,
  output logic [ADDR_W-1:0] curAddr,
  output logic [DATA_W-1:0] dataQ,
  output logic [PORT_W-1:0] portQ,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic              irq
);

  localparam int NUM_SLOTS = 2;

  logic [NUM_SLOTS-1:0][CNT_W-1:0]  cntVec;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] baseVec;
  logic [NUM_SLOTS-1:0]             cntHit;
  logic stallF, nfbF, errF;

  wire ctrlHit  = regWe && (regAddr == REG_AW'(OFF_CTRL));
  wire flagsHit = regWe && (regAddr == REG_AW'(OFF_FLAGS));
  wire portHit  = regWe && (regAddr == REG_AW'(OFF_PORT));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : gSlot
    localparam logic [REG_AW-1:0] CNT_OFF  = REG_AW'(OFF_SLOT0 + i * SLOT_STEP);
    localparam logic [REG_AW-1:0] BASE_OFF = REG_AW'(OFF_SLOT0 + i * SLOT_STEP + OFF_BASE);

    logic [CNT_W-1:0]  cntR;
    logic [ADDR_W-1:0] baseR;
    wire sel      = (strb.slotSel == 1'(i));
    wire baseHit  = regWe && (regAddr == BASE_OFF);
    assign cntHit[i] = regWe && (regAddr == CNT_OFF);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntR <= '0;
      end else if (strb.flush) begin
        cntR <= '0;
      end else if (cntHit[i]) begin
        cntR <= regWdata[CNT_W-1:0];
      end else if (sel && strb.advance) begin
        cntR <= cntR - CNT_W'(1);
      end else if (sel && strb.abortSlot) begin
        cntR <= '0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseR <= '0;
      end else if (baseHit) begin
        baseR <= regWdata[ADDR_W-1:0];
      end else if (sel && strb.advance) begin
        baseR <= baseR + ADDR_W'(1);
      end
    end

    assign cntVec[i]   = cntR;
    assign baseVec[i]  = baseR;
    assign slotLive[i] = (cntR != '0);
  end

  wire anyCntWrite = |cntHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      portQ <= '0;
      dataQ <= '0;
    end else begin
      if (ctrlHit)       ctrlQ <= regWdata[CTRL_W-1:0] & CTRL_KEEP;
      if (portHit)       portQ <= regWdata[PORT_W-1:0];
      if (strb.loadData) dataQ <= memRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallF <= 1'b0;
      nfbF   <= 1'b0;
      errF   <= 1'b0;
    end else begin
      if (strb.setStall)    stallF <= 1'b1;
      else if (anyCntWrite) stallF <= 1'b0;
      if (strb.setNfb)      nfbF <= 1'b1;
      else if (anyCntWrite) nfbF <= 1'b0;
      if (strb.setErr)      errF <= 1'b1;
      else if (flagsHit)    errF <= 1'b0;
    end
  end

  assign curAddr       = baseVec[strb.slotSel];
  assign curCountIsOne = (cntVec[strb.slotSel] == CNT_W'(1));

  assign irq = ctrlQ[BIT_IRQEN] &
               ((stallF & ctrlQ[BIT_STALL]) |
                (nfbF   & ctrlQ[BIT_NFB])   |
                (errF   & ctrlQ[BIT_ERR]));

  always_comb begin
    regRdata = '0;
    if (regAddr == REG_AW'(OFF_CTRL)) begin
      regRdata[CTRL_W-1:0] = ctrlQ;
    end else if (regAddr == REG_AW'(OFF_FLAGS)) begin
      regRdata[BIT_STALL] = stallF;
      regRdata[BIT_NFB]   = nfbF;
      regRdata[BIT_ERR]   = errF;
    end else if (regAddr == REG_AW'(OFF_PORT)) begin
      regRdata[PORT_W-1:0] = portQ;
    end else if (regAddr == REG_AW'(OFF_STATUS)) begin
      regRdata[STATE_LSB+1:STATE_LSB] = chState;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (regAddr == REG_AW'(OFF_SLOT0 + i * SLOT_STEP))
          regRdata[CNT_W-1:0] = cntVec[i];
        if (regAddr == REG_AW'(OFF_SLOT0 + i * SLOT_STEP + OFF_BASE))
          regRdata[ADDR_W-1:0] = baseVec[i];
      end
    end
  end

endmodule

// File: rtl/pdma_ctrl.sv
module pdma_ctrl
  import pdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] slotLive,
  input  logic       curCountIsOne,
  input  logic       perReq,
  input  logic       memValid,
  input  logic       memErr,
  output ctlStrobe_t strb,
  output chState_e   chState,
  output logic       memReq,
  output logic       perAck
);

  phase_e   phaseQ, phaseD;
  logic     curSlot, curSlotD;
  logic     finish;
  chState_e stateD;

  wire otherLive = slotLive[!curSlot];
  wire curLive   = slotLive[curSlot];

  always_comb begin
    strb         = '0;
    strb.slotSel = curSlot;
    phaseD       = phaseQ;
    curSlotD     = curSlot;
    finish       = 1'b0;
    unique case (phaseQ)
      PH_WAIT: begin
        if (!enable) begin
          strb.flush = 1'b1;
        end else if (!curLive && otherLive) begin
          curSlotD = !curSlot;
        end else if (curLive && perReq) begin
          phaseD = PH_READ;
        end
      end
      PH_READ: begin
        if (memValid) begin
          if (memErr) begin
            strb.abortSlot = 1'b1;
            strb.setErr    = 1'b1;
            finish         = 1'b1;
            phaseD         = PH_WAIT;
          end else begin
            strb.loadData = 1'b1;
            phaseD        = PH_PUSH;
          end
        end
      end
      PH_PUSH: begin
        strb.advance = 1'b1;
        finish       = curCountIsOne;
        phaseD       = PH_WAIT;
      end
      default: phaseD = PH_WAIT;
    endcase
    if (finish) begin
      strb.setNfb   = otherLive;
      strb.setStall = !otherLive;
      curSlotD      = !curSlot;
    end
  end

  always_comb begin
    if (!enable) begin
      stateD = (phaseQ == PH_WAIT) ? CH_IDLE : chState;
    end else begin
      unique case (slotLive)
        2'b00:   stateD = CH_STALL;
        2'b11:   stateD = CH_NEXT;
        default: stateD = CH_ON;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ  <= PH_WAIT;
      curSlot <= 1'b0;
      chState <= CH_IDLE;
    end else begin
      phaseQ  <= phaseD;
      curSlot <= curSlotD;
      chState <= stateD;
    end
  end

  assign memReq = (phaseQ == PH_READ);
  assign perAck = (phaseQ == PH_PUSH);

endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int REG_AW = 8,
  parameter int REG_DW = 32,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWe,
  input  logic [REG_DW-1:0] regWdata,
  output logic [REG_DW-1:0] regRdata,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memErr,
  input  logic              perReq,
  output logic              perAck,
  output logic [DATA_W-1:0] perData,
  output logic [PORT_W-1:0] perPort,
  output logic              irq
);

  ctlStrobe_t        strb;
  chState_e          chState;
  logic [1:0]        slotLive;
  logic              curCountIsOne;
  logic [CTRL_W-1:0] ctrlBits;

  pdma_regs_dp #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
    .REG_AW(REG_AW), .REG_DW(REG_DW), .PORT_W(PORT_W)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .strb(strb), .chState(chState), .memRdata(memRdata),
    .slotLive(slotLive), .curCountIsOne(curCountIsOne),
    .curAddr(memAddr), .dataQ(perData), .portQ(perPort),
    .ctrlQ(ctrlBits), .irq(irq)
  );

  pdma_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .enable(ctrlBits[BIT_EN]), .slotLive(slotLive), .curCountIsOne(curCountIsOne),
    .perReq(perReq), .memValid(memValid), .memErr(memErr),
    .strb(strb), .chState(chState), .memReq(memReq), .perAck(perAck)
  );

endmodule

// File: rtl/pdma_checker.sv
module pdma_checker
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memValid,
  input logic              memErr,
  input logic              perAck,
  input logic              irq,
  input chState_e          chState,
  input logic [CTRL_W-1:0] ctrlBits
);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && $stable(memAddr)));

  assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    perAck |=> !perAck);

  assert_ack_after_data_R12: assert property (@(posedge clk) disable iff (!rstN)
    perAck |-> $past(memValid && !memErr && memReq));

  assert_err_no_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memValid && memErr) |=> !perAck);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ctrlBits[BIT_IRQEN]);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (chState == CH_IDLE) |-> (!memReq && !perAck));

endmodule

bind pdma_channel pdma_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAddr(memAddr),
  .memValid(memValid), .memErr(memErr), .perAck(perAck), .irq(irq),
  .chState(chState), .ctrlBits(ctrlBits)
);

// File: tb/tb_pdma_channel.sv
module tb_pdma_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memValid = 1'b0;
  logic [7:0]  memRdata = '0;
  logic        memErr = 1'b0;
  logic        perReq = 1'b0;
  logic        perAck;
  logic [7:0]  perData;
  logic [3:0]  perPort;
  logic        irq;

  int          nChecks = 0;
  int          nFails = 0;
  int          cycles = 0;
  logic [31:0] errAddr = 32'hFFFF_FFFF;
  logic [31:0] sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pdma_channel dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .memReq(memReq), .memAddr(memAddr), .memValid(memValid),
    .memRdata(memRdata), .memErr(memErr), .perReq(perReq), .perAck(perAck),
    .perData(perData), .perPort(perPort), .irq(irq)
  );

  function automatic logic [7:0] memByte(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // memory model: one response, one cycle after the request is seen
  always @(posedge clk) begin
    if (!rstN) begin
      memValid <= 1'b0;
      memErr   <= 1'b0;
    end else begin
      memValid <= memReq && !memValid;
      memRdata <= memByte(memAddr);
      memErr   <= memReq && (memAddr == errAddr);
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    cycles++;
    if (rstN && perAck) begin
      if (sbQ.size() == 0) begin
        check("R4 unexpected byte", {24'h0, perData}, 32'hDEAD);
      end else begin
        logic [31:0] a;
        a = sbQ.pop_front();
        check("R4 byte data", {24'h0, perData}, {24'h0, memByte(a)});
      end
    end
  end

  task automatic expectBytes(logic [31:0] base, int n);
    for (int k = 0; k < n; k++) sbQ.push_back(base + 32'(k));
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic rdChk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic drain(int extra);
    while (sbQ.size() != 0) @(negedge clk);
    repeat (extra) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdChk("R1 ctrl", 8'h00, 0);
    rdChk("R1 flags", 8'h04, 0);
    rdChk("R1 status", 8'h0C, 0);
    rdChk("R1 count0", 8'h20, 0);
    check("R1 irq/memReq/perAck", {29'h0, irq, memReq, perAck}, 0);

    // R2 port and control masking
    wr(8'h08, 32'h1F5);
    rdChk("R2 port readback", 8'h08, 32'h5);
    check("R2 perPort", {28'h0, perPort}, 32'h5);
    wr(8'h00, 32'hFF);
    rdChk("R2 ctrl mask", 8'h00, 32'h5B);
    wr(8'h00, 32'h0);

    // R10 count written while disabled is discarded
    wr(8'h20, 32'd3);
    rdChk("R10 disabled count write", 8'h20, 0);
    rdChk("R3 idle when disabled", 8'h0C, 32'h00);

    // R3 states
    wr(8'h00, 32'h5B);
    rdChk("R3 stall when empty", 8'h0C, 32'h10);
    check("R9 irq low no flags", {31'h0, irq}, 0);
    wr(8'h24, 32'h100);
    wr(8'h20, 32'd3);
    rdChk("R3 on with one slot", 8'h0C, 32'h20);
    rdChk("R4 count0 loaded", 8'h20, 32'd3);
    wr(8'h34, 32'h200);
    wr(8'h30, 32'hABC0002);
    rdChk("R4 count keeps low 16 bits", 8'h30, 32'd2);
    rdChk("R3 next with two slots", 8'h0C, 32'h30);

    // R5/R6 slot 0 then slot 1
    expectBytes(32'h100, 3);
    expectBytes(32'h200, 2);
    perReq = 1'b1;
    drain(6);
    rdChk("R5/R6 flags nfb+stall", 8'h04, 32'h3);
    rdChk("R6 stall state", 8'h0C, 32'h10);
    rdChk("R4 count1 drained", 8'h30, 0);
    rdChk("R4 base1 advanced", 8'h34, 32'h202);
    rdChk("R4 base0 advanced", 8'h24, 32'h103);
    check("R9 irq with flags", {31'h0, irq}, 1);

    // R7 count write clears flags; refill slot 0
    expectBytes(32'h103, 2);
    wr(8'h20, 32'd2);
    rdChk("R7 flags cleared", 8'h04, 0);
    check("R9 irq after clear", {31'h0, irq}, 0);
    drain(6);
    rdChk("R6 stall only", 8'h04, 32'h1);
    perReq = 1'b0;

    // R7 zero count loads nothing
    wr(8'h30, 32'd0);
    rdChk("R7 zero count flags", 8'h04, 0);
    rdChk("R7 zero count state", 8'h0C, 32'h10);

    // R8 memory error in slot 1, continue with slot 0
    wr(8'h34, 32'h300);
    wr(8'h30, 32'd4);
    wr(8'h24, 32'h400);
    wr(8'h20, 32'd1);
    errAddr = 32'h301;
    expectBytes(32'h300, 1);
    expectBytes(32'h400, 1);
    perReq = 1'b1;
    drain(10);
    perReq = 1'b0;
    rdChk("R8 flags err+nfb+stall", 8'h04, 32'hB);
    rdChk("R8 slot abandoned", 8'h30, 0);
    rdChk("R8 address not advanced past fault", 8'h34, 32'h301);
    wr(8'h04, 32'h0);
    rdChk("R8 error cleared", 8'h04, 32'h3);
    errAddr = 32'hFFFF_FFFF;

    // R9 gating
    wr(8'h00, 32'h1B);
    check("R9 irq master off", {31'h0, irq}, 0);
    wr(8'h00, 32'h5B);
    check("R9 irq master on", {31'h0, irq}, 1);
    wr(8'h00, 32'h58);
    check("R9 irq only err enabled", {31'h0, irq}, 0);

    // R10 disable during a read: byte finishes, then idle and flushed
    wr(8'h34, 32'h500);
    wr(8'h30, 32'd5);
    expectBytes(32'h500, 1);
    perReq = 1'b1;
    @(negedge clk);
    while (!memReq) @(negedge clk);
    regWe = 1'b1; regAddr = 8'h00; regWdata = 32'h0; perReq = 1'b0;
    @(negedge clk);
    regWe = 1'b0;
    drain(5);
    rdChk("R10 idle after drain", 8'h0C, 32'h00);
    rdChk("R10 slot flushed", 8'h30, 0);
    check("R10 no request", {31'h0, memReq}, 0);
    repeat (5) @(negedge clk);
    check("R10 no stray bytes", 32'(sbQ.size()), 0);

    finishRun();
  end

endmodule